// File: doc/BRIEF.md
# Set-Associative Translation Cache Test Port

This block holds a small translation cache of four ways, each with eight entries. Each entry pairs a 20-bit linear page number, a valid flag and three attribute flags (dirty, user, writable) with a 20-bit physical page number. The only access to the array is through two 32-bit registers: a command word and a data word. Power-up confidence code uses them to plant entries and then probe them. There is no page walk, no translation path for normal execution and no replacement policy. Software names the way on every write.

A write of the command word acts at once. With its command bit clear, it stores an entry built from the command and data words. With the command bit set, it searches the set that the page number selects and loads the outcome into the data word. A strobe that marks a write of the page-directory base register invalidates the whole array. Any register access made at a privilege level other than 0 is refused and produces a one-cycle fault pulse.

Top module: `tlb_test_port`

## Requirements
- R1: After reset both registers read as zero and every entry is invalid, so a search with the valid bit set misses.
- R2: A data-word write keeps physical page [31:12], hit flag [4] and way number [3:2]. Bits [11:5] and [1:0] read back as zero.
- R3: A command-word write keeps page number [31:12], valid [11] and the attribute pairs [10:5] (dirty/complement [10:9], user/complement [8:7], writable/complement [6:5]) along with command bit [0]. Bits [4:1] read back as zero.
- R4: A command write with bit 0 = 0 and the stored data hit flag = 1 fills the entry in the way given by data [3:2], at set index = command bits [14:12]. If the hit flag is 0, the array is left unchanged.
- R5: A command write with bit 0 = 1 compares the four entries of the selected set. When exactly one matches, the data word becomes {physical page, 7'b0, 1, way, 2'b0}, and it can be read in the next cycle.
- R6: When no entry matches, or more than one does, the search clears the hit flag and leaves the physical page and way fields unchanged.
- R7: The valid bit of the command word must equal the stored valid flag for a match, in the same way as any page-number bit.
- R8: For each attribute pair X/X#, 10 stores 1 and matches only a stored 1, and 01 stores 0 and matches only a stored 0. Pairs 00 and 11 store the X bit and match either stored value.
- R9: The invalidate strobe clears all valid flags. An entry write in the same cycle still lands.
- R10: An access with privilege level not 0 changes no state, reads as zero, and raises the fault output for exactly the following cycle. Accesses at level 0 raise no fault.
- R11: Read data is combinational: it is the selected register when a read is made at level 0, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Register write request |
| acc_rd | input | 1 | Register read request |
| acc_sel | input | 1 | 0 selects the command word, 1 the data word |
| acc_wdata | input | 32 | Write data |
| cpl | input | 2 | Current privilege level |
| cr3_wr | input | 1 | Invalidate-all strobe |
| acc_rdata | output | 32 | Read data |
| gp_fault | output | 1 | Protection-fault pulse |

## Verification
The bench targets duplicate tags placed in two ways of one set. A design that reported the first match would return a hit instead of a miss. Searches whose attribute pairs are 01, 10 or the don't-care codes check the match logic: a design that ignored the pairs, or treated 00 as a strict compare, would give the wrong hit flag. A search that uses a valid bit of 0, or a page number that differs only above the set index, must miss. An entry write issued with the hit flag clear must leave the array untouched. The bench also issues an invalidate together with a write, then a refused access, and checks that the refused access leaves both registers intact and pulses the fault for exactly one cycle.

// File: rtl/tlb_test_port.sv
module tlb_test_port #(
  parameter int WAYS = 4,
  parameter int SETS = 8,
  parameter int PN   = 20
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_wr,
  input  logic        acc_rd,
  input  logic        acc_sel,
  input  logic [31:0] acc_wdata,
  input  logic [1:0]  cpl,
  input  logic        cr3_wr,
  output logic [31:0] acc_rdata,
  output logic        gp_fault
);
  localparam int IW = $clog2(SETS);
  localparam int WW = $clog2(WAYS);
  localparam int N  = WAYS * SETS;
  localparam int EW = WW + IW;
  localparam logic [31:0] CMD_MASK = 32'hFFFF_FFE1;
  localparam logic [31:0] DAT_MASK = 32'hFFFF_F01C;

  logic [31:0]   cmd_q, dat_q;
  logic [PN-1:0] tag_q  [N];
  logic [PN-1:0] phys_q [N];
  logic [N-1:0]  vld_q, d_q, u_q, w_q;

  wire priv_ok = (cpl == 2'd0);
  wire cmd_we  = acc_wr && priv_ok && !acc_sel;
  wire dat_we  = acc_wr && priv_ok && acc_sel;
  wire [PN-1:0] lin = acc_wdata[31:32-PN];
  wire [IW-1:0] set = acc_wdata[12 +: IW];
  wire ent_we  = cmd_we && !acc_wdata[0] && dat_q[4];
  wire look    = cmd_we && acc_wdata[0];
  wire [EW-1:0] wr_idx = {dat_q[2 +: WW], set};

  function automatic logic pair_ok(input logic x, input logic xn, input logic s);
    return (x == xn) || (s == x);
  endfunction

  logic [WAYS-1:0] hit;
  logic [WW-1:0]   hit_way;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      logic [EW-1:0] e;
      e = {WW'(w), set};
      hit[w] = (vld_q[e] == acc_wdata[11]) && (tag_q[e] == lin) &&
               pair_ok(acc_wdata[10], acc_wdata[9], d_q[e]) &&
               pair_ok(acc_wdata[8],  acc_wdata[7], u_q[e]) &&
               pair_ok(acc_wdata[6],  acc_wdata[5], w_q[e]);
      if (hit[w]) hit_way = WW'(w);
    end
  end

  wire one_hit = $onehot(hit);
  wire [EW-1:0] rd_idx = {hit_way, set};

  assign acc_rdata = (acc_rd && priv_ok) ? (acc_sel ? dat_q : cmd_q) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      dat_q    <= '0;
      gp_fault <= 1'b0;
      vld_q    <= '0;
      d_q      <= '0;
      u_q      <= '0;
      w_q      <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]  <= '0;
        phys_q[i] <= '0;
      end
    end else begin
      gp_fault <= (acc_wr || acc_rd) && !priv_ok;
      if (cmd_we) cmd_q <= acc_wdata & CMD_MASK;
      if (dat_we) dat_q <= acc_wdata & DAT_MASK;
      if (look) begin
        if (one_hit) dat_q <= {phys_q[rd_idx], 7'b0, 1'b1, 2'(hit_way), 2'b0};
        else         dat_q[4] <= 1'b0;
      end
      if (cr3_wr) vld_q <= '0;
      if (ent_we) begin
        tag_q[wr_idx]  <= lin;
        phys_q[wr_idx] <= dat_q[31:32-PN];
        vld_q[wr_idx]  <= acc_wdata[11];
        d_q[wr_idx]    <= acc_wdata[10];
        u_q[wr_idx]    <= acc_wdata[8];
        w_q[wr_idx]    <= acc_wdata[6];
      end
    end
  end

  // R10
  fault_on_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_wr || acc_rd) && cpl != 2'd0) |=> gp_fault);
  // R10
  no_fault_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc_wr || acc_rd) || cpl == 2'd0) |=> !gp_fault);
  // R10
  user_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && cpl != 2'd0) |=> ($stable(cmd_q) && $stable(dat_q)));
  // R9
  cr3_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cr3_wr && !ent_we) |=> (vld_q == '0));
  // R6
  miss_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (look && !one_hit) |=> (!dat_q[4] && $stable(dat_q[31:5]) && $stable(dat_q[3:0])));
endmodule

// File: tb/tlb_test_port_test.sv
module tlb_test_port_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, acc_wr, acc_rd, acc_sel, cr3_wr, gp_fault;
  logic [31:0] acc_wdata, acc_rdata;
  logic [1:0] cpl;

  tlb_test_port uut (.clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
    .acc_sel(acc_sel), .acc_wdata(acc_wdata), .cpl(cpl), .cr3_wr(cr3_wr),
    .acc_rdata(acc_rdata), .gp_fault(gp_fault));

  int tests = 0, fails = 0;
  bit [19:0] m_tag [32];
  bit [19:0] m_phys [32];
  bit m_v [32], m_d [32], m_u [32], m_w [32];
  bit [31:0] m_cmd = 0, m_dat = 0;
  bit m_fault = 0;
  logic [31:0] got;
  logic flt;

  function automatic bit pm(bit x, bit xn, bit s);
    return (x == xn) || (s == x);
  endfunction

  function automatic bit [31:0] cw(bit [19:0] lin, bit v, bit [5:0] a, bit c);
    return {lin, v, a, 4'b0, c};
  endfunction

  function automatic bit [31:0] dw(bit [19:0] ph, bit ht, bit [1:0] rep);
    return {ph, 7'b0, ht, rep, 2'b0};
  endfunction

  task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step(string rq, bit wr, bit sel, bit [31:0] wd, bit rd, bit [1:0] pl, bit c3);
    @(negedge clk);
    acc_wr = wr; acc_sel = sel; acc_wdata = wd; acc_rd = rd; cpl = pl; cr3_wr = c3;
    #1;
    got = acc_rdata; flt = gp_fault;
    chk(rq, "rdata", acc_rdata, (rd && pl == 0) ? (sel ? m_dat : m_cmd) : 32'd0);
    chk("R10", "fault", {31'd0, gp_fault}, {31'd0, m_fault});
    @(posedge clk);
    m_fault = (wr || rd) && pl != 0;
    if (c3) for (int i = 0; i < 32; i++) m_v[i] = 0;
    if (wr && pl == 0) begin
      if (sel) m_dat = wd & 32'hFFFF_F01C;
      else begin
        int idx = int'(wd[14:12]);
        m_cmd = wd & 32'hFFFF_FFE1;
        if (!wd[0]) begin
          if (m_dat[4]) begin
            int e = int'(m_dat[3:2]) * 8 + idx;
            m_tag[e] = wd[31:12]; m_phys[e] = m_dat[31:12];
            m_v[e] = wd[11]; m_d[e] = wd[10]; m_u[e] = wd[8]; m_w[e] = wd[6];
          end
        end else begin
          int n = 0, hw = 0;
          for (int w = 0; w < 4; w++) begin
            int e = w * 8 + idx;
            if (m_v[e] == wd[11] && m_tag[e] == wd[31:12] && pm(wd[10], wd[9], m_d[e]) &&
                pm(wd[8], wd[7], m_u[e]) && pm(wd[6], wd[5], m_w[e])) begin
              n++; hw = w;
            end
          end
          if (n == 1) m_dat = dw(m_phys[hw * 8 + idx], 1'b1, 2'(hw));
          else m_dat[4] = 1'b0;
        end
      end
    end
  endtask

  task automatic rd_dat(string rq, bit [31:0] exp);
    step(rq, 0, 1, 0, 1, 0, 0);
    chk(rq, "data word", got, exp);
  endtask

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 0; acc_wr = 0; acc_rd = 0; acc_sel = 0; acc_wdata = 0; cpl = 0; cr3_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    step("R1", 0, 0, 0, 1, 0, 0);
    chk("R1", "command word", got, 32'd0);
    rd_dat("R1", 32'd0);
    step("R1", 1, 0, cw(20'h0, 1, 6'b010101, 1), 0, 0, 0);
    rd_dat("R1", 32'd0);
    // R2 data word layout
    step("R2", 1, 1, 32'hFFFF_FFFF, 0, 0, 0);
    rd_dat("R2", 32'hFFFF_F01C);
    // R3 command word layout (also fills way 3 set 7)
    step("R3", 1, 0, 32'hFFFF_FFFE, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 0, 0);
    chk("R3", "command word", got, 32'hFFFF_FFE0);
    step("R9", 0, 0, 0, 0, 0, 1);
    // R4 / R5 write then hit
    step("R4", 1, 1, dw(20'hABCDE, 1, 2), 0, 0, 0);
    step("R4", 1, 0, cw(20'h12345, 1, 6'b101010, 0), 0, 0, 0);
    step("R5", 1, 0, cw(20'h12345, 1, 6'b101010, 1), 0, 0, 0);
    rd_dat("R5", dw(20'hABCDE, 1, 2));
    // R8 strict pair mismatch
    step("R8", 1, 0, cw(20'h12345, 1, 6'b011010, 1), 0, 0, 0);
    rd_dat("R8", dw(20'hABCDE, 0, 2));
    // R8 don't-care pairs
    step("R8", 1, 0, cw(20'h12345, 1, 6'b001100, 1), 0, 0, 0);
    rd_dat("R8", dw(20'hABCDE, 1, 2));
    // R7 valid bit compared
    step("R7", 1, 0, cw(20'h12345, 0, 6'b101010, 1), 0, 0, 0);
    rd_dat("R7", dw(20'hABCDE, 0, 2));
    // R4 same set, tag differs above the index
    step("R4", 1, 0, cw(20'h1234D, 1, 6'b101010, 1), 0, 0, 0);
    rd_dat("R4", dw(20'hABCDE, 0, 2));
    // R4 hit flag clear blocks the write
    step("R4", 1, 1, dw(20'h11111, 0, 1), 0, 0, 0);
    step("R4", 1, 0, cw(20'h00007, 1, 6'b010101, 0), 0, 0, 0);
    step("R4", 1, 0, cw(20'h00007, 1, 6'b010101, 1), 0, 0, 0);
    rd_dat("R4", dw(20'h11111, 0, 1));
    step("R4", 1, 1, dw(20'h22222, 1, 0), 0, 0, 0);
    step("R4", 1, 0, cw(20'h00007, 1, 6'b010101, 0), 0, 0, 0);
    step("R5", 1, 0, cw(20'h00007, 1, 6'b010101, 1), 0, 0, 0);
    rd_dat("R5", dw(20'h22222, 1, 0));
    // R6 duplicate tag in two ways
    step("R6", 1, 1, dw(20'h33333, 1, 3), 0, 0, 0);
    step("R6", 1, 0, cw(20'h00007, 1, 6'b010101, 0), 0, 0, 0);
    step("R6", 1, 0, cw(20'h00007, 1, 6'b010101, 1), 0, 0, 0);
    rd_dat("R6", dw(20'h33333, 0, 3));
    // R9 invalidate
    step("R9", 0, 0, 0, 0, 0, 1);
    step("R9", 1, 0, cw(20'h12345, 1, 6'b101010, 1), 0, 0, 0);
    rd_dat("R9", dw(20'h33333, 0, 3));
    step("R9", 1, 1, dw(20'h44444, 1, 1), 0, 0, 0);
    step("R9", 1, 0, cw(20'h00002, 1, 6'b100110, 0), 0, 0, 1);
    step("R9", 1, 0, cw(20'h00002, 1, 6'b100110, 1), 0, 0, 0);
    rd_dat("R9", dw(20'h44444, 1, 1));
    // R10 refused access
    step("R10", 1, 1, 32'hFFFF_FFFF, 0, 3, 0);
    step("R10", 0, 1, 0, 1, 0, 0);
    chk("R10", "fault pulse", {31'd0, flt}, 32'd1);
    chk("R10", "data kept", got, dw(20'h44444, 1, 1));
    step("R10", 0, 1, 0, 1, 1, 0);
    chk("R10", "user read", got, 32'd0);
    step("R10", 0, 0, 0, 0, 0, 0);
    chk("R10", "fault pulse", {31'd0, flt}, 32'd1);
    step("R10", 0, 0, 0, 0, 0, 0);
    chk("R10", "pulse width", {31'd0, flt}, 32'd0);
    // R11 no read request
    step("R11", 0, 1, 0, 0, 0, 0);
    chk("R11", "idle rdata", got, 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule